// File: doc/BRIEF.md
# System Option Register with Timed Write Protection

This block is an 8-bit configuration register on a microcontroller's peripheral bus. It holds power-up and clock-select bits for the analog converter, the IRQ sensitivity choice, the oscillator start-up delay enable, the clock-monitor enable and a two-bit watchdog rate. It drives these settings as decoded outputs to the blocks that use them. Those blocks are outside this design: the converter, the clock monitor and the watchdog counter.

Four of the bits set system behaviour that must not drift once software has chosen it. These are the IRQ sensitivity, the oscillator delay enable and the two rate bits. In normal mode they accept a single write, and only during the first bus cycles after reset. In special mode they can be written at any time. The remaining bits can be written at any time in any mode.

Each clock cycle is one bus cycle. Writes take effect at the clock edge. Reads are combinational and show the current contents.

Top module: `sysopt_reg`

## Requirements
- R1: The register responds only at bus address 0x1039. A write to any other address changes nothing, and bus_rdata reads 0x00 whenever bus_addr is not 0x1039.
- R2: A synchronous reset loads 0x10. The oscillator-delay bit is 1 and every other bit is 0.
- R3: Bit layout: bit 7 is converter power-up, bit 6 is converter clock select, bit 5 is IRQ edge select, bit 4 is oscillator delay enable, bit 3 is clock-monitor enable, bit 2 is unused, and bits 1:0 are the watchdog rate. Each bit drives its own output.
- R4: Bit 2 always reads 0. Writing 1 to it has no effect.
- R5: In normal mode the protected bits (5, 4, 1, 0) are updated only by a write that lands on one of the first 64 clock edges after reset is released, counting the first edge as 0. A write on edge 63 is accepted and a write on edge 64 is rejected.
- R6: In normal mode only the first write inside that window updates the protected bits. Every later write leaves them unchanged and reports no error.
- R7: Bits 7, 6 and 3 take the written value on every write to the register, in any mode and at any time.
- R8: In special mode the protected bits take every write, with no limit on time or count.
- R9: wdog_rate equals bits 1:0. wdog_div_log2 equals 15 + 2·rate, which gives total divisions of 2^15, 2^17, 2^19 and 2^21.
- R10: irq_edge_sel is 1 for edge-sensitive IRQ and 0 for level-sensitive IRQ, and it follows bit 5.
- R11: A read in the cycle right after a write edge returns the new contents, with no added latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; one edge per bus cycle |
| rst | input | 1 | Synchronous active-high reset |
| special_mode | input | 1 | 1 selects special mode, in which the protected bits have no write limit |
| bus_addr | input | 16 | Bus address |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data; register contents when the address matches, otherwise 0 |
| adc_pwr_up | output | 1 | Converter power-up (bit 7) |
| adc_clk_sel | output | 1 | Converter clock select (bit 6) |
| irq_edge_sel | output | 1 | 1 = edge-sensitive IRQ, 0 = level-sensitive IRQ |
| osc_dly_en | output | 1 | Oscillator start-up delay enable (bit 4) |
| clk_mon_en | output | 1 | Clock-monitor enable (bit 3) |
| wdog_rate | output | 2 | Watchdog rate select |
| wdog_div_log2 | output | 5 | Base-2 log of the total watchdog division |

## Verification
The write path is exercised with all-ones, all-zeros, single-bit patterns and each of the four rate codes. Each pattern is written in three situations: inside the open window, after a first write has used the window, and after the 64-edge limit has passed. Comparing a free bit with a protected bit from the same write shows whether the masking is applied per bit. Writes placed exactly on edges 63 and 64 after reset show whether the window boundary is off by one. The same patterns repeated in special mode show whether the mode input lifts the limit. A write of 0xFF to the neighbouring address, followed by a read there, shows whether the address decode is exact.

// File: rtl/sysopt_pkg.sv
package sysopt_pkg;

    localparam logic [15:0] OPT_ADDR  = 16'h1039;
    localparam logic [7:0]  PROT_MASK = 8'h33;
    localparam logic [7:0]  FREE_MASK = 8'hC8;
    localparam logic [7:0]  RESET_VAL = 8'h10;

    typedef struct packed {
        logic       adc_pwr;
        logic       adc_clk;
        logic       irq_edge;
        logic       osc_dly;
        logic       clk_mon;
        logic       rsv;
        logic [1:0] wd_rate;
    } opt_t;

    function automatic opt_t merge_write(opt_t cur, logic [7:0] wd, logic prot_ok);
        logic [7:0] m;
        logic [7:0] c;
        m = FREE_MASK | (prot_ok ? PROT_MASK : 8'h00);
        c = cur;
        return opt_t'((c & ~m) | (wd & m));
    endfunction

    function automatic logic [7:0] read_view(opt_t cur);
        opt_t v;
        v     = cur;
        v.rsv = 1'b0;
        return v;
    endfunction

endpackage

// File: rtl/sysopt_window.sv
module sysopt_window #(
    parameter int unsigned WINDOW = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic special_mode,
    input  logic wr_hit,
    output logic win_open
);
    localparam int unsigned CW = $clog2(WINDOW + 1);
    localparam logic [CW-1:0] LIMIT = CW'(WINDOW);

    logic [CW-1:0] cnt_q;
    logic          used_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            used_q <= 1'b0;
        end else begin
            if (cnt_q != LIMIT) begin
                cnt_q <= cnt_q + CW'(1);
            end
            if (wr_hit && !special_mode && win_open) begin
                used_q <= 1'b1;
            end
        end
    end

    assign win_open = (cnt_q < LIMIT) && !used_q;

endmodule

// File: rtl/sysopt_store.sv
module sysopt_store
    import sysopt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       prot_en,
    output opt_t       q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= opt_t'(RESET_VAL);
        end else if (wr_en) begin
            q <= merge_write(q, wr_data, prot_en);
        end
    end
endmodule

// File: rtl/sysopt_rate.sv
module sysopt_rate #(
    parameter int unsigned PRESCALE_LOG2 = 15,
    parameter int unsigned STEP_LOG2     = 2,
    parameter int unsigned DIV_W         = 5
) (
    input  logic [1:0]       sel,
    output logic [1:0]       rate,
    output logic [DIV_W-1:0] div_log2
);
    localparam int unsigned NCODES = 4;

    logic [DIV_W-1:0] table_w [NCODES];

    for (genvar g = 0; g < NCODES; g++) begin : g_code
        assign table_w[g] = DIV_W'(PRESCALE_LOG2 + STEP_LOG2 * g);
    end

    assign rate     = sel;
    assign div_log2 = table_w[sel];
endmodule

// File: rtl/sysopt_reg.sv
module sysopt_reg
    import sysopt_pkg::*;
#(
    parameter int unsigned WINDOW        = 64,
    parameter int unsigned PRESCALE_LOG2 = 15,
    parameter int unsigned STEP_LOG2     = 2,
    parameter int unsigned DIV_W         = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             special_mode,
    input  logic [15:0]      bus_addr,
    input  logic             bus_wr,
    input  logic [7:0]       bus_wdata,
    output logic [7:0]       bus_rdata,
    output logic             adc_pwr_up,
    output logic             adc_clk_sel,
    output logic             irq_edge_sel,
    output logic             osc_dly_en,
    output logic             clk_mon_en,
    output logic [1:0]       wdog_rate,
    output logic [DIV_W-1:0] wdog_div_log2
);
    logic       addr_hit;
    logic       wr_hit;
    logic       win_open;
    logic       prot_en;
    opt_t       opt_q;
    logic [7:0] opt_bits;

    assign addr_hit = (bus_addr == OPT_ADDR);
    assign wr_hit   = bus_wr && addr_hit;
    assign prot_en  = special_mode || win_open;

    sysopt_window #(.WINDOW(WINDOW)) win_i (
        .clk          (clk),
        .rst          (rst),
        .special_mode (special_mode),
        .wr_hit       (wr_hit),
        .win_open     (win_open)
    );

    sysopt_store store_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_hit),
        .wr_data (bus_wdata),
        .prot_en (prot_en),
        .q       (opt_q)
    );

    sysopt_rate #(
        .PRESCALE_LOG2 (PRESCALE_LOG2),
        .STEP_LOG2     (STEP_LOG2),
        .DIV_W         (DIV_W)
    ) rate_i (
        .sel      (opt_q.wd_rate),
        .rate     (wdog_rate),
        .div_log2 (wdog_div_log2)
    );

    assign opt_bits     = opt_q;
    assign bus_rdata    = addr_hit ? read_view(opt_q) : 8'h00;
    assign adc_pwr_up   = opt_q.adc_pwr;
    assign adc_clk_sel  = opt_q.adc_clk;
    assign irq_edge_sel = opt_q.irq_edge;
    assign osc_dly_en   = opt_q.osc_dly;
    assign clk_mon_en   = opt_q.clk_mon;

endmodule

// File: rtl/sysopt_chk.sv
module sysopt_chk
    import sysopt_pkg::*;
#(
    parameter int unsigned PRESCALE_LOG2 = 15,
    parameter int unsigned STEP_LOG2     = 2,
    parameter int unsigned DIV_W         = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             special_mode,
    input logic [15:0]      bus_addr,
    input logic             bus_wr,
    input logic [7:0]       bus_wdata,
    input logic [7:0]       bus_rdata,
    input logic             clk_mon_en,
    input logic             adc_pwr_up,
    input logic             irq_edge_sel,
    input logic [DIV_W-1:0] wdog_div_log2,
    input logic             win_open,
    input logic [7:0]       opt_bits
);
    logic hit_w;
    assign hit_w = bus_wr && (bus_addr == OPT_ADDR);

    a_r1_other_addr_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_addr != OPT_ADDR) |-> (bus_rdata == 8'h00));

    a_r1_other_addr_no_write: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr != OPT_ADDR) |=> $stable(opt_bits));

    a_r4_bit2_zero: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[2] == 1'b0);

    a_r5_closed_keeps_protected: assert property (@(posedge clk) disable iff (rst)
        (!win_open && !special_mode) |=> $stable(opt_bits & PROT_MASK));

    a_r6_single_use: assert property (@(posedge clk) disable iff (rst)
        (hit_w && win_open && !special_mode) |=> !win_open);

    a_r7_free_bits_follow: assert property (@(posedge clk) disable iff (rst)
        hit_w |=> (clk_mon_en == $past(bus_wdata[3]) && adc_pwr_up == $past(bus_wdata[7])));

    a_r8_special_takes_write: assert property (@(posedge clk) disable iff (rst)
        (hit_w && special_mode) |=> ((opt_bits & PROT_MASK) == ($past(bus_wdata) & PROT_MASK)));

    a_r9_div_matches_rate: assert property (@(posedge clk) disable iff (rst)
        wdog_div_log2 == DIV_W'(PRESCALE_LOG2 + STEP_LOG2 * opt_bits[1:0]));

    a_r10_irq_matches_read: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == OPT_ADDR) |-> (irq_edge_sel == bus_rdata[5]));
endmodule

bind sysopt_reg sysopt_chk #(
    .PRESCALE_LOG2 (PRESCALE_LOG2),
    .STEP_LOG2     (STEP_LOG2),
    .DIV_W         (DIV_W)
) chk_i (
    .clk           (clk),
    .rst           (rst),
    .special_mode  (special_mode),
    .bus_addr      (bus_addr),
    .bus_wr        (bus_wr),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .clk_mon_en    (clk_mon_en),
    .adc_pwr_up    (adc_pwr_up),
    .irq_edge_sel  (irq_edge_sel),
    .wdog_div_log2 (wdog_div_log2),
    .win_open      (win_open),
    .opt_bits      (opt_bits)
);

// File: tb/sysopt_reg_tb.sv
`timescale 1ns/1ps
module sysopt_reg_tb_top;
    localparam logic [15:0] REG_A = 16'h1039;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        special_mode = 1'b0;
    logic [15:0] bus_addr = 16'h0000;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic        adc_pwr_up, adc_clk_sel, irq_edge_sel, osc_dly_en, clk_mon_en;
    logic [1:0]  wdog_rate;
    logic [4:0]  wdog_div_log2;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sysopt_reg dut_i (
        .clk(clk), .rst(rst), .special_mode(special_mode),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .adc_pwr_up(adc_pwr_up), .adc_clk_sel(adc_clk_sel),
        .irq_edge_sel(irq_edge_sel), .osc_dly_en(osc_dly_en), .clk_mon_en(clk_mon_en),
        .wdog_rate(wdog_rate), .wdog_div_log2(wdog_div_log2)
    );

    typedef struct {
        string      tag;
        logic [7:0] rd;
        logic [7:0] val;
    } exp_t;

    exp_t sbq[$];

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    // Monitor: pops one expected item per cycle and compares at the falling edge
    always @(negedge clk) begin
        if (sbq.size() > 0) begin
            exp_t e;
            e = sbq.pop_front();
            chk(e.tag, "rdata", int'(bus_rdata), int'(e.rd));
            chk(e.tag, "adc_pwr_up", int'(adc_pwr_up), int'(e.val[7]));
            chk(e.tag, "adc_clk_sel", int'(adc_clk_sel), int'(e.val[6]));
            chk(e.tag, "irq_edge_sel", int'(irq_edge_sel), int'(e.val[5]));
            chk(e.tag, "osc_dly_en", int'(osc_dly_en), int'(e.val[4]));
            chk(e.tag, "clk_mon_en", int'(clk_mon_en), int'(e.val[3]));
            chk(e.tag, "wdog_rate", int'(wdog_rate), int'(e.val[1:0]));
            chk(e.tag, "wdog_div_log2", int'(wdog_div_log2), 15 + 2 * int'(e.val[1:0]));
        end
    end

    // All tasks are entered just after a rising edge
    task automatic do_reset(bit sp);
        special_mode = sp;
        bus_wr = 1'b0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    task automatic do_write(logic [15:0] a, logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic expect_reg(string tag, logic [7:0] v);
        exp_t e;
        bus_addr = REG_A;
        bus_wr   = 1'b0;
        e.tag = tag; e.rd = v; e.val = v;
        sbq.push_back(e);
        @(posedge clk);
        #1;
    endtask

    task automatic expect_off(string tag, logic [15:0] a, logic [7:0] v);
        exp_t e;
        bus_addr = a;
        bus_wr   = 1'b0;
        e.tag = tag; e.rd = 8'h00; e.val = v;
        sbq.push_back(e);
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R2 reset value
        do_reset(1'b0);
        expect_reg("R2_reset", 8'h10);
        // R1 off-address read gives zero
        expect_off("R1_off_read", 16'h1038, 8'h10);
        // R3 R4 R5 first write in window, bit 2 dropped
        do_write(REG_A, 8'hFF);
        expect_reg("R3_R4_R11_first_write", 8'hFB);
        // R6 second write: only free bits move
        do_write(REG_A, 8'h00);
        expect_reg("R6_second_write", 8'h33);
        // R7 clock monitor writable after window used
        do_write(REG_A, 8'h08);
        expect_reg("R7_cme_late", 8'h3B);
        // R1 neighbouring address write ignored
        do_write(16'h1038, 8'h00);
        expect_reg("R1_off_write", 8'h3B);

        // R5 boundary: edge 63 accepted
        do_reset(1'b0);
        repeat (63) @(posedge clk);
        #1;
        do_write(REG_A, 8'h21);
        expect_reg("R5_edge63", 8'h21);
        expect_reg("R10_edge_sel", 8'h21);

        // R5 boundary: edge 64 rejected, free bits still taken
        do_reset(1'b0);
        repeat (64) @(posedge clk);
        #1;
        do_write(REG_A, 8'hEF);
        expect_reg("R5_edge64", 8'hD8);

        // R8 special mode: repeated protected writes, each rate code
        do_reset(1'b1);
        repeat (100) @(posedge clk);
        #1;
        do_write(REG_A, 8'h21);
        expect_reg("R8_R9_rate1", 8'h21);
        do_write(REG_A, 8'h12);
        expect_reg("R8_R9_rate2", 8'h12);
        do_write(REG_A, 8'h04);
        expect_reg("R8_R4_bit2", 8'h00);
        do_write(REG_A, 8'h33);
        expect_reg("R8_R9_rate3", 8'h33);
        do_write(REG_A, 8'h10);
        expect_reg("R10_level", 8'h10);

        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule